// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block sits between the receive byte stream from the PHY side and the write port of a receive FIFO. Each incoming frame is marked by a start beat and an end beat. On the start beat the block decides whether the frame is kept or discarded. It then passes the bytes of a kept frame to the FIFO, either with the four trailing FCS bytes or without them. When an accepted frame completes, it raises a one-cycle receive-ready pulse and, unless interrupts are masked, a one-cycle receive interrupt.

The main reason to discard a frame is the port's own transmission coming back. In half duplex the PHY echoes every transmitted frame. If the own-frame drop mode is set, a frame that starts while the local transmitter is active is ignored in full. In full duplex the echo does not occur, so frames that arrive during transmission are always stored. The drop mode therefore only takes effect in half duplex.

Top module: `rx_frame_filter`

## Requirements
- R1: A frame whose start beat sees drop_own=1, tx_active=1 and full_duplex=0 is discarded. It causes no fifo_wr, no rx_ready and no rx_irq.
- R2: In half duplex with drop_own=0, a frame that starts while tx_active=1 is stored like any other frame.
- R3: With full_duplex=1, a frame is stored whatever drop_own and tx_active are at its start.
- R4: With keep_fcs=1 at the start beat, all N bytes of an accepted frame are written to the FIFO in arrival order.
- R5: With keep_fcs=0 at the start beat, only the first N-4 bytes are written, in order. The last four bytes are withheld, and a frame of 4 bytes or fewer writes nothing.
- R6: For each accepted frame, rx_ready is high for exactly one cycle, two clock cycles after the end beat is sampled. That is one cycle after the write caused by the end beat.
- R7: rx_irq pulses together with rx_ready unless irq_mask was 1 at the frame's start beat. In that case rx_irq stays low for the frame.
- R8: The accept decision, keep_fcs and irq_mask are sampled on the start beat and held to the end beat. A change of tx_active inside a frame has no effect.
- R9: A beat with rx_valid=1 that is not inside a frame, meaning no start beat has been seen since the last end beat, is ignored.
- R10: Each write is registered. fifo_wr is high for one cycle, in the cycle after the input beat that causes it, with fifo_data holding the byte being written.
- R11: While rst_n is low, and right after reset, fifo_wr, rx_ready and rx_irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of frame (qualified by rx_valid) |
| rx_eof | input | 1 | Last byte of frame (qualified by rx_valid) |
| rx_data | input | 8 | Receive byte |
| tx_active | input | 1 | Local transmitter busy |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| drop_own | input | 1 | Discard frames starting during own transmission (half duplex) |
| keep_fcs | input | 1 | Store the four FCS bytes |
| irq_mask | input | 1 | Suppress receive interrupts |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| rx_ready | output | 1 | One-cycle frame-received pulse |
| rx_irq | output | 1 | One-cycle receive interrupt |

## Verification
The hardest case to reach is a frame whose start-of-frame conditions differ from those later in the same frame. For example, transmission may stop right after the start beat, or begin just after it. The bench inverts tx_active on every beat after the first. Only a decision held from the start beat then gives the expected result. The bench sweeps all 32 mode and transmit combinations over frame lengths on both sides of the four-byte FCS boundary. It places a stray valid byte between frames, so that writes outside a frame would show up in the stored byte count.

// File: rtl/rx_filter_pkg.sv
package rx_filter_pkg;
  localparam int unsigned FCS_BYTES = 4;

  // frame is kept unless it is our own echo in half duplex with drop enabled
  function automatic logic frame_admit(input logic drop, input logic tx,
                                       input logic fd);
    return !(drop && tx && !fd);
  endfunction

  // number of bytes a frame of len bytes leaves in the FIFO
  function automatic int unsigned stored_len(input int unsigned len,
                                             input logic keep,
                                             input int unsigned fcs);
    if (keep) return len;
    return (len > fcs) ? len - fcs : 0;
  endfunction
endpackage

// File: rtl/rx_admit.sv
module rx_admit
  import rx_filter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic sof,
  input  logic eof,
  input  logic tx_active,
  input  logic full_duplex,
  input  logic drop_own,
  input  logic keep_fcs,
  input  logic irq_mask,
  output logic beat_kept,
  output logic sof_kept,
  output logic eof_kept,
  output logic drop_sof,
  output logic keep_cur,
  output logic irq_en_cur
);
  logic in_frame_q, acc_q, keep_q, irqen_q;
  logic admit_now, start_beat;

  assign start_beat = valid && sof;
  assign admit_now  = frame_admit(drop_own, tx_active, full_duplex);

  assign beat_kept  = start_beat ? admit_now : (valid && in_frame_q && acc_q);
  assign sof_kept   = start_beat && admit_now;
  assign eof_kept   = beat_kept && eof;
  assign drop_sof   = start_beat && !admit_now;
  assign keep_cur   = start_beat ? keep_fcs : keep_q;
  assign irq_en_cur = start_beat ? !irq_mask : irqen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      acc_q      <= 1'b0;
      keep_q     <= 1'b0;
      irqen_q    <= 1'b0;
    end else if (valid) begin
      if (sof) begin
        acc_q   <= admit_now;
        keep_q  <= keep_fcs;
        irqen_q <= !irq_mask;
      end
      if (eof)      in_frame_q <= 1'b0;
      else if (sof) in_frame_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_fcs_strip.sv
module rx_fcs_strip #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_kept,
  input  logic          sof_kept,
  input  logic          keep,
  input  logic [DW-1:0] data,
  output logic          wr,
  output logic [DW-1:0] wdata
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] line_q [DEPTH];
  logic [CW-1:0] fill_q;
  logic [CW-1:0] fill_n;
  logic          line_full;

  assign fill_n    = sof_kept ? '0 : fill_q;
  assign line_full = (fill_n == CW'(DEPTH));

  always_ff @(posedge clk) begin
    line_q[0] <= beat_kept ? data : line_q[0];
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (beat_kept) line_q[g] <= line_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      wr     <= 1'b0;
      wdata  <= '0;
    end else begin
      wr <= 1'b0;
      if (beat_kept) begin
        if (!line_full) fill_q <= fill_n + 1'b1;
        else            fill_q <= fill_n;
        if (keep) begin
          wr    <= 1'b1;
          wdata <= data;
        end else if (line_full) begin
          wr    <= 1'b1;
          wdata <= line_q[DEPTH-1];
        end
      end
    end
  end
endmodule

// File: rtl/rx_done_gen.sv
module rx_done_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic eof_kept,
  input  logic irq_en,
  output logic ready,
  output logic irq
);
  logic stage_q, irq_stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q     <= 1'b0;
      irq_stage_q <= 1'b0;
      ready       <= 1'b0;
      irq         <= 1'b0;
    end else begin
      stage_q     <= eof_kept;
      irq_stage_q <= eof_kept && irq_en;
      ready       <= stage_q;
      irq         <= irq_stage_q;
    end
  end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rx_filter_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_active,
  input  logic          full_duplex,
  input  logic          drop_own,
  input  logic          keep_fcs,
  input  logic          irq_mask,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_data,
  output logic          rx_ready,
  output logic          rx_irq
);
  logic beat_kept, sof_kept, eof_kept, drop_sof, keep_cur, irq_en_cur;

  rx_admit u_admit (
    .clk(clk), .rst_n(rst_n), .valid(rx_valid), .sof(rx_sof), .eof(rx_eof),
    .tx_active(tx_active), .full_duplex(full_duplex), .drop_own(drop_own),
    .keep_fcs(keep_fcs), .irq_mask(irq_mask), .beat_kept(beat_kept),
    .sof_kept(sof_kept), .eof_kept(eof_kept), .drop_sof(drop_sof),
    .keep_cur(keep_cur), .irq_en_cur(irq_en_cur)
  );

  rx_fcs_strip #(.DW(DW), .DEPTH(FCS_BYTES)) u_strip (
    .clk(clk), .rst_n(rst_n), .beat_kept(beat_kept), .sof_kept(sof_kept),
    .keep(keep_cur), .data(rx_data), .wr(fifo_wr), .wdata(fifo_data)
  );

  rx_done_gen u_done (
    .clk(clk), .rst_n(rst_n), .eof_kept(eof_kept), .irq_en(irq_en_cur),
    .ready(rx_ready), .irq(rx_irq)
  );
endmodule

// File: rtl/rx_frame_filter_chk.sv
module rx_frame_filter_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] rx_data,
  input logic          beat_kept,
  input logic          eof_kept,
  input logic          drop_sof,
  input logic          keep_cur,
  input logic          fifo_wr,
  input logic [DW-1:0] fifo_data,
  input logic          rx_ready,
  input logic          rx_irq
);
  p_write_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(beat_kept));

  p_drop_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    drop_sof |=> !fifo_wr);

  p_keep_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_kept && keep_cur) |=> (fifo_wr && fifo_data == $past(rx_data)));

  p_ready_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eof_kept |=> ##1 rx_ready);

  p_ready_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !rx_ready);

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_ready);
endmodule

bind rx_frame_filter rx_frame_filter_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .beat_kept(beat_kept),
  .eof_kept(eof_kept), .drop_sof(drop_sof), .keep_cur(keep_cur),
  .fifo_wr(fifo_wr), .fifo_data(fifo_data), .rx_ready(rx_ready),
  .rx_irq(rx_irq)
);

// File: tb/rx_frame_filter_tb.sv
module rx_frame_filter_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = 0;
  logic tx_active = 0, full_duplex = 0, drop_own = 0, keep_fcs = 0, irq_mask = 0;
  logic fifo_wr, rx_ready, rx_irq;
  logic [7:0] fifo_data;

  int tests = 0, fails = 0;
  int cyc = 0;
  int n_wr = 0, n_rdy = 0, n_irq = 0, rdy_cyc = -1;
  logic [7:0] got [16];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_frame_filter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .tx_active(tx_active),
    .full_duplex(full_duplex), .drop_own(drop_own), .keep_fcs(keep_fcs),
    .irq_mask(irq_mask), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .rx_ready(rx_ready), .rx_irq(rx_irq)
  );

  always @(negedge clk) begin
    if (fifo_wr) begin
      if (n_wr < 16) got[n_wr] = fifo_data;
      n_wr = n_wr + 1;
    end
    if (rx_ready) begin
      n_rdy = n_rdy + 1;
      rdy_cyc = cyc;
    end
    if (rx_irq) n_irq = n_irq + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int len, input logic [7:0] base,
                           input logic drop, input logic tx, input logic fd,
                           input logic keep, input logic mask, input string tag);
    int eof_cyc = 0;
    int exp_n, bad;
    logic acc;
    n_wr = 0; n_rdy = 0; n_irq = 0; rdy_cyc = -1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data = base + 8'(i);
      tx_active = (i == 0) ? tx : ~tx;
      drop_own = drop; full_duplex = fd;
      keep_fcs = (i == 0) ? keep : ~keep;
      irq_mask = (i == 0) ? mask : ~mask;
      if (i == len - 1) eof_cyc = cyc;
    end
    @(negedge clk);
    rx_sof = 0; rx_eof = 0; rx_data = 8'hEE;
    @(negedge clk);
    rx_valid = 0;
    repeat (4) @(negedge clk);
    acc = !(drop && tx && !fd);
    exp_n = !acc ? 0 : (keep ? len : (len > 4 ? len - 4 : 0));
    check({tag, " stored count"}, n_wr, exp_n);
    bad = 0;
    for (int i = 0; i < exp_n && i < 16; i++)
      if (got[i] != base + 8'(i)) bad++;
    check({tag, " byte order"}, bad, 0);
    check("R6 ready pulses", n_rdy, acc ? 1 : 0);
    if (acc) check("R6 ready cycle", rdy_cyc, eof_cyc + 2);
    check("R7 irq pulses", n_irq, (acc && !mask) ? 1 : 0);
  endtask

  initial begin
    int lens [5] = '{1, 3, 4, 5, 9};
    int fr = 0;
    string tag;
    repeat (3) @(negedge clk);
    check("R11 fifo_wr in reset", int'(fifo_wr), 0);
    check("R11 ready in reset", int'(rx_ready), 0);
    check("R11 irq in reset", int'(rx_irq), 0);
    rst_n = 1;
    @(negedge clk);
    rx_valid = 1; rx_data = 8'h11;
    @(negedge clk);
    rx_valid = 0;
    @(negedge clk);
    check("R9 stray beat after reset", int'(fifo_wr), 0);
    check("R11 outputs after reset", int'(rx_ready | rx_irq), 0);
    for (int m = 0; m < 32; m++) begin
      for (int l = 0; l < 5; l++) begin
        logic d, t, f, k, q;
        {d, t, f, k, q} = 5'(m);
        if (d && t && !f)  tag = "R1 R8 drop";
        else if (f && t)   tag = "R3 R8 full duplex";
        else if (t)        tag = "R2 R8 half duplex echo";
        else               tag = k ? "R4 R10 keep fcs" : "R5 R10 strip fcs";
        if (!(d && t && !f)) tag = {tag, k ? " R4" : " R5"};
        run_frame(lens[l], 8'(fr * 16), d, t, f, k, q, tag);
        fr++;
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule